// File: doc/BRIEF.md
# Registered Command Buffer with Chip-Select Output Hold

This block sits between a memory controller and a row of memory devices. On every rising clock edge it captures a 28-bit command/address word and drives two identical copies of it onto a 56-bit output bus, so that each captured bit feeds two loads. A static mapping input selects one of two input layouts. The layout decides which two input bits carry the pair of chip-selects.

When a gate-enable input is high and both chip-selects in the incoming word are high, no device is being addressed. In that case the whole output bus keeps its previous value, which saves switching power. When the gate-enable input is low, the chip-select bits are captured like any other data bit and the bus updates on every edge.

An active-low reset clears the register at once, without waiting for a clock, and holds the outputs low. Release of the reset is synchronized to the clock. The register ignores its inputs during the two edges that follow the release. The first capture happens on the third rising edge after reset goes high, so the outputs cannot glitch as the block comes out of reset.

Top module: `registered_cmd_buffer`

## Requirements
- R1: The output is two copies of the captured 28-bit word. Bits q[27:0] and q[55:28] are always equal.
- R2: The word on d is captured on a rising clock edge. When no hold applies, it appears on q right after that edge.
- R3: With map_sel low (layout A), the chip-selects are d[13] and d[14]. With map_sel high (layout B), they are d[21] and d[23]. map_sel changes only while reset is low.
- R4: If gate_en is high and both chip-select bits of the current layout are high at an edge, q keeps its previous value through that edge.
- R5: If gate_en is high and either chip-select bit is low at an edge, q takes the new word.
- R6: With gate_en low, q takes the new word on every edge, including when both chip-select bits are high.
- R7: When rst_n goes low, q becomes zero at once, without waiting for a clock edge.
- R8: After rst_n rises, q stays zero through the first two rising edges. The first capture happens on the third rising edge.
- R9: While rst_n is low, q stays zero even when the hold condition of R4 is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| map_sel | input | 1 | Static layout select: 0 selects layout A, 1 selects layout B |
| gate_en | input | 1 | Enables the chip-select output hold |
| d | input | 28 | Command/address word |
| q | output | 56 | Two copies of the registered word |

## Verification
The hardest case to reach from the ports is a hold that happens in the same cycle as another event. Two such overlaps matter. The first is a hold that happens while reset is asserted asynchronously. The second is a hold that happens in the two-edge window just after reset release. A third hard case is a word whose chip-selects are high in the layout that is not selected. This word looks like a hold but must update. The stimulus drives these cases on purpose. It drops reset in the middle of a cycle while both chip-selects are high. It releases reset while the input data is not zero. It also sets the chip-select positions of the other layout high while the active positions are low, and then the reverse. All of this runs on top of random words with gate_en both low and high.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    localparam int WORD_W = 28;
    localparam int COPIES = 2;
    localparam int OUT_W  = COPIES * WORD_W;

    // chip-select bit positions per input layout
    localparam int CS0_POS_A = 13;
    localparam int CS1_POS_A = 14;
    localparam int CS0_POS_B = 21;
    localparam int CS1_POS_B = 23;

    typedef enum logic {
        MAP_A = 1'b0,
        MAP_B = 1'b1
    } map_mode_e;

    typedef struct packed {
        logic cs0;
        logic cs1;
    } cs_pair_t;

    function automatic cs_pair_t pick_cs(input logic [WORD_W-1:0] w, input map_mode_e m);
        cs_pair_t p;
        if (m == MAP_B) begin
            p.cs0 = w[CS0_POS_B];
            p.cs1 = w[CS1_POS_B];
        end else begin
            p.cs0 = w[CS0_POS_A];
            p.cs1 = w[CS1_POS_A];
        end
        return p;
    endfunction

endpackage

// File: rtl/cmdbuf_rst_sync.sv
module cmdbuf_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic run
);

    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], 1'b1};
        end
    end

    assign run = stage_q[STAGES-1];

    // run may only rise after the release has been seen in the earlier stage
    p_run_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(stage_q[STAGES-2]));

endmodule

// File: rtl/cmdbuf_gate.sv
module cmdbuf_gate
    import cmdbuf_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] word,
    input  map_mode_e    mode,
    input  logic         gate_en,
    output logic         hold
);

    cs_pair_t cs;

    always_comb begin
        cs   = pick_cs(word, mode);
        hold = gate_en && cs.cs0 && cs.cs1;
    end

endmodule

// File: rtl/cmdbuf_capture.sv
module cmdbuf_capture #(
    parameter int W      = 28,
    parameter int NCOPY  = 2,
    localparam int OW    = W * NCOPY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          hold,
    input  logic [W-1:0]  d,
    output logic [OW-1:0] q
);

    logic [W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (run && !hold) begin
            word_q <= d;
        end
    end

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        assign q[c*W +: W] = word_q;
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hold) |=> $stable(q));

    p_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !hold) |=> (q[W-1:0] == $past(d)));

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (q == '0));

    p_reset_low_r9: assert property (@(posedge clk)
        (!rst_n) |-> (q == '0));

endmodule

// File: rtl/registered_cmd_buffer.sv
module registered_cmd_buffer
    import cmdbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_sel,
    input  logic              gate_en,
    input  logic [WORD_W-1:0] d,
    output logic [OUT_W-1:0]  q
);

    logic      run;
    logic      hold;
    map_mode_e mode;

    assign mode = map_mode_e'(map_sel);

    cmdbuf_rst_sync #(.STAGES(2)) u_rst_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run)
    );

    cmdbuf_gate #(.W(WORD_W)) u_gate (
        .word    (d),
        .mode    (mode),
        .gate_en (gate_en),
        .hold    (hold)
    );

    cmdbuf_capture #(.W(WORD_W), .NCOPY(COPIES)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .hold  (hold),
        .d     (d),
        .q     (q)
    );

    p_copies_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q[OUT_W-1:WORD_W] == q[WORD_W-1:0]);

endmodule

// File: tb/registered_cmd_buffer_bench.sv
module registered_cmd_buffer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          map_sel = 1'b0;
    logic          gate_en = 1'b0;
    logic [W-1:0]  d = '0;
    logic [2*W-1:0] q;

    int checks = 0;
    int errors = 0;
    string cur_req = "R7";

    logic [W-1:0] model_q = '0;
    int           sync_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    registered_cmd_buffer u_registered_cmd_buffer (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel),
        .gate_en(gate_en), .d(d), .q(q)
    );

    function automatic logic model_hold();
        if (map_sel) return gate_en && d[21] && d[23];
        return gate_en && d[13] && d[14];
    endfunction

    task automatic compare(input string req);
        checks++;
        if (q !== {model_q, model_q}) begin
            errors++;
            $display("FAIL %s: q=%h expected=%h", req, q, {model_q, model_q});
        end
        checks++;
        if (q[2*W-1:W] !== q[W-1:0]) begin
            errors++;
            $display("FAIL R1: upper=%h lower=%h expected equal", q[2*W-1:W], q[W-1:0]);
        end
    endtask

    // one rising edge: advance the reference, then compare a quarter period later
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            model_q = '0;
            sync_cnt = 0;
        end else begin
            if (sync_cnt >= 2 && !model_hold()) model_q = d;
            if (sync_cnt < 2) sync_cnt++;
        end
        #(CLK_PERIOD/4);
        compare(cur_req);
    endtask

    task automatic drop_reset();
        rst_n = 1'b0;
        model_q = '0;
        sync_cnt = 0;
        #1;
        compare("R7");
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        drop_reset();
        cur_req = "R7";
        for (int i = 0; i < 3; i++) step();

        // R8: release with nonzero data; first two edges must leave q low
        d = 28'h5a5_1c3e;
        rst_n = 1'b1;
        cur_req = "R8";
        for (int i = 0; i < 4; i++) begin
            step();
            d = W'($urandom);
        end

        // R6: gate disabled, cs bits high still update
        gate_en = 1'b0;
        cur_req = "R6";
        for (int i = 0; i < 20; i++) begin
            d = W'($urandom);
            d[13] = 1'b1; d[14] = 1'b1;
            step();
        end

        // R2 / R5 / R4 mixed random in layout A with gate on
        gate_en = 1'b1;
        cur_req = "R5";
        for (int i = 0; i < 40; i++) begin
            d = W'($urandom);
            d[14] = 1'b0;
            step();
        end
        cur_req = "R4";
        for (int i = 0; i < 40; i++) begin
            d = W'($urandom);
            if (i % 3 != 0) begin d[13] = 1'b1; d[14] = 1'b1; end
            step();
        end

        // R9: drop reset mid-cycle while hold condition is present
        d = '1;
        drop_reset();
        cur_req = "R9";
        for (int i = 0; i < 3; i++) step();

        // R3: switch layout only under reset, then exercise layout B
        map_sel = 1'b1;
        step();
        rst_n = 1'b1;
        cur_req = "R8";
        for (int i = 0; i < 3; i++) begin
            d = W'($urandom) | 28'h0a0_0000;
            step();
        end
        cur_req = "R3";
        for (int i = 0; i < 40; i++) begin
            d = W'($urandom);
            case (i % 4)
                0: begin d[13] = 1'b1; d[14] = 1'b1; d[21] = 1'b0; end
                1: begin d[21] = 1'b1; d[23] = 1'b1; d[13] = 1'b0; end
                2: begin d[21] = 1'b1; d[23] = 1'b0; end
                default: ;
            endcase
            step();
        end

        cur_req = "R2";
        gate_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            d = W'($urandom);
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule